// File: doc/BRIEF.md
# Port Pin Edge Interrupt Unit

This block watches the input pins of one port and raises a single interrupt request for the port when a selected edge appears on any pin. Each pin has its own 2-bit field in `mode_i` that picks the edge it reacts to: none, rising, falling or both. A qualifying edge sets that pin's bit in a sticky status register. Software reads that register to find which pin caused the request.

The pins are asynchronous to the clock, so each one passes through a synchronizer. An edge is found by comparing the newest synchronized sample with the sample before it. A read strobe returns the status bits and clears them in the same access. An edge that lands in the same cycle as the read survives the clear. The request output is the OR of all status bits. It stays high until software clears the register. Only edges are detected; a steady level never raises a request.

Top module: `port_edge_irq`

## Requirements
- R1: While reset is asserted, and right after it is released, `status_o` is all zeros and `irq_o` is 0.
- R2: Pin i's mode is `mode_i[2*i+1:2*i]`. The value 01 means a low-to-high transition on that pin sets `status_o[i]`.
- R3: Mode value 10 means a high-to-low transition sets `status_o[i]`, and a low-to-high transition does not.
- R4: Mode value 11 means a transition in either direction sets `status_o[i]`.
- R5: Mode value 00 means transitions on that pin never set its status bit.
- R6: A pin change that is first sampled at clock edge k is visible in `status_o` after edge k+2, and not before.
- R7: When `status_rd_i` is high in a cycle, `status_o` shows the current bits during that cycle. At the closing edge, every bit clears unless it had a new event in that cycle.
- R8: An event that falls in the same cycle as a clearing read leaves its bit set after the read. The other bits still clear.
- R9: `irq_o` equals the OR of the status bits. Once set, it stays high until a read clears every bit.
- R10: Changing a pin's mode does not clear that pin's status bit. It also does not create an event by itself, even when the pin is held high.
- R11: A pin held at a constant level raises no new event after its status bit is cleared.
- R12: A pin level that is already present when reset is released is not reported as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| mode_i | input | 2*NUM_PINS | Per-pin edge mode, 2 bits per pin |
| status_rd_i | input | 1 | Read strobe; clears status at the closing edge |
| status_o | output | NUM_PINS | Sticky per-pin event bits |
| irq_o | output | 1 | Port interrupt request |

## Verification
Two things can happen in the same cycle: a clearing read and a newly qualified edge. The bench provokes this on purpose. It raises a pin, then asserts the read strobe exactly in the cycle that the edge reaches the status register. It checks that the pin which just fired keeps its bit while an older bit on another pin is dropped. A behavioural model keeps a queue of sampled pin values. It recomputes the expected status and request on every clock, including during a long stretch of pseudo-random pin, mode and read traffic, so the overlap also occurs unplanned.

// File: rtl/pei_pkg.sv
package pei_pkg;

  localparam int unsigned MODE_W = 2;

  // bit 0 selects rising, bit 1 selects falling
  typedef enum logic [MODE_W-1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] smp_cur_o,
  output logic [NUM_PINS-1:0] smp_prev_o,
  output logic                armed_o
);

  localparam int unsigned WARM_W = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] stg_q, stg_d;
  logic [NUM_PINS-1:0]                  prev_q, prev_d;
  logic [WARM_W-1:0]                    warm_q, warm_d;
  logic                                 warm_en;

  // next state
  always_comb begin
    stg_d[0] = pin_i;
    for (int s = 1; s < SYNC_STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
    prev_d  = stg_q[SYNC_STAGES-1];
    warm_en = ~warm_q[WARM_W-1];
    warm_d  = {warm_q[WARM_W-2:0], 1'b1};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q  <= stg_d;
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
    end else if (warm_en) begin
      warm_q <= warm_d;
    end
  end

  assign smp_cur_o  = stg_q[SYNC_STAGES-1];
  assign smp_prev_o = prev_q;
  assign armed_o    = warm_q[WARM_W-1];

endmodule

// File: rtl/pei_detect.sv
module pei_detect
  import pei_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  localparam int unsigned MODE_BITS = NUM_PINS * MODE_W
) (
  input  logic [NUM_PINS-1:0]  smp_cur_i,
  input  logic [NUM_PINS-1:0]  smp_prev_i,
  input  logic                 armed_i,
  input  logic [MODE_BITS-1:0] mode_i,
  output logic [NUM_PINS-1:0]  ev_o
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    edge_mode_e sel;
    logic       rise, fall, hit;

    assign sel  = edge_mode_e'(mode_i[i*MODE_W +: MODE_W]);
    assign rise =  smp_cur_i[i] & ~smp_prev_i[i];
    assign fall = ~smp_cur_i[i] &  smp_prev_i[i];

    always_comb begin
      unique case (sel)
        EDGE_OFF:  hit = 1'b0;
        EDGE_RISE: hit = rise;
        EDGE_FALL: hit = fall;
        EDGE_BOTH: hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end

    assign ev_o[i] = armed_i & hit;
  end

endmodule

// File: rtl/pei_status.sv
module pei_status #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] ev_i,
  input  logic                rd_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0] status_q, status_d;
  logic                irq_q, irq_d;
  logic                upd_en;

  // next state: a clearing read loses to a same-cycle event
  always_comb begin
    status_d = (rd_i ? '0 : status_q) | ev_i;
    irq_d    = |status_d;
    upd_en   = rd_i | (|ev_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else if (upd_en) begin
      status_q <= status_d;
      irq_q    <= irq_d;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  // R7: a read with no event empties the register
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && ev_i == '0) |=> (status_q == '0));

  // R8: an event is recorded even when a read closes the same cycle
  a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((status_q & $past(ev_i)) == $past(ev_i)));

  // R9: without a read no bit is ever dropped
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R9: request flop tracks the OR of the status flops
  a_r9_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (status_q != '0));

endmodule

// File: rtl/port_edge_irq.sv
module port_edge_irq
  import pei_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned MODE_BITS  = NUM_PINS * MODE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  pin_i,
  input  logic [MODE_BITS-1:0] mode_i,
  input  logic                 status_rd_i,
  output logic [NUM_PINS-1:0]  status_o,
  output logic                 irq_o
);

  logic [NUM_PINS-1:0] smp_cur, smp_prev, ev;
  logic                armed;

  pei_sync #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_i),
    .smp_cur_o (smp_cur),
    .smp_prev_o(smp_prev),
    .armed_o   (armed)
  );

  pei_detect #(
    .NUM_PINS(NUM_PINS)
  ) i_detect (
    .smp_cur_i (smp_cur),
    .smp_prev_i(smp_prev),
    .armed_i   (armed),
    .mode_i    (mode_i),
    .ev_o      (ev)
  );

  pei_status #(
    .NUM_PINS(NUM_PINS)
  ) i_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_i    (ev),
    .rd_i    (status_rd_i),
    .status_o(status_o),
    .irq_o   (irq_o)
  );

  // R11: no event while both samples agree, whatever the mode
  a_r11_steady_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_cur == smp_prev) |-> (ev == '0));

  // R12: nothing fires before the sample pipeline is full
  a_r12_warmup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (status_o == '0));

endmodule

// File: tb/test_port_edge_irq.sv
module test_port_edge_irq;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin;
  logic [2*NP-1:0] mode;
  logic          rd;
  logic [NP-1:0] status_o;
  logic          irq_o;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  port_edge_irq i_port_edge_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin),
    .mode_i     (mode),
    .status_rd_i(rd),
    .status_o   (status_o),
    .irq_o      (irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: queue of pin samples taken at each edge
  logic [NP-1:0] m_st;
  logic [NP-1:0] m_ev;
  logic [NP-1:0] hist [$];
  int            n_edges;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = '0;
      hist.delete();
      n_edges = 0;
    end else begin
      n_edges++;
      m_ev = '0;
      if (n_edges >= 4) begin
        for (int i = 0; i < NP; i++) begin
          if (hist[1][i] && !hist[2][i] && mode[2*i])   m_ev[i] = 1'b1;
          if (!hist[1][i] && hist[2][i] && mode[2*i+1]) m_ev[i] = 1'b1;
        end
      end
      m_st = (rd ? '0 : m_st) | m_ev;
      hist.push_front(pin);
      if (hist.size() > 4) void'(hist.pop_back());
    end
  end

  task automatic chk(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " status vs model"}, status_o, m_st);
      chk({cur_req, " R9 irq vs model"}, {7'd0, irq_o}, {7'd0, |m_st});
    end
  end

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    pin   = '0;
    mode  = '0;
    rd    = 1'b0;
    tick(3);
    chk("R1 status in reset", status_o, 8'h00);
    chk("R1 irq in reset", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    tick(1);
    chk("R1 status after release", status_o, 8'h00);
    tick(3);

    // R2 rising on pin0, R6 latency
    cur_req = "R2";
    mode[1:0] = 2'b01;
    pin[0] = 1'b1;
    tick(2);
    chk("R6 not yet visible", status_o, 8'h00);
    tick(1);
    chk("R2/R6 rising sets bit0", status_o, 8'h01);
    chk("R9 irq high", {7'd0, irq_o}, 8'h01);

    // R7 read returns then clears
    cur_req = "R7";
    rd = 1'b1;
    #1 chk("R7 value during read", status_o, 8'h01);
    tick(1);
    rd = 1'b0;
    chk("R7 cleared after read", status_o, 8'h00);
    chk("R7 irq low after read", {7'd0, irq_o}, 8'h00);

    // R3 falling on pin1; pin0 falling in rising mode ignored
    cur_req = "R3";
    mode[3:2] = 2'b10;
    pin[1] = 1'b1;
    tick(4);
    chk("R3 rising ignored in falling mode", status_o, 8'h00);
    pin[1] = 1'b0;
    pin[0] = 1'b0;
    tick(3);
    chk("R3 falling sets bit1 only", status_o, 8'h02);

    // R9 hold
    cur_req = "R9";
    tick(5);
    chk("R9 status held", status_o, 8'h02);
    chk("R9 irq held", {7'd0, irq_o}, 8'h01);
    rd = 1'b1; tick(1); rd = 1'b0;

    // R4 both edges on pin2
    cur_req = "R4";
    mode[5:4] = 2'b11;
    pin[2] = 1'b1;
    tick(3);
    chk("R4 rise in both mode", status_o, 8'h04);
    rd = 1'b1; tick(1); rd = 1'b0;
    pin[2] = 1'b0;
    tick(3);
    chk("R4 fall in both mode", status_o, 8'h04);
    rd = 1'b1; tick(1); rd = 1'b0;

    // R5 disabled pin3
    cur_req = "R5";
    pin[3] = 1'b1;
    tick(3);
    pin[3] = 1'b0;
    tick(4);
    chk("R5 disabled pin silent", status_o, 8'h00);
    chk("R5 irq silent", {7'd0, irq_o}, 8'h00);

    // R11 level holds no retrigger
    cur_req = "R11";
    pin[2] = 1'b1;
    tick(3);
    chk("R11 edge seen", status_o, 8'h04);
    rd = 1'b1; tick(1); rd = 1'b0;
    tick(6);
    chk("R11 held level quiet", status_o, 8'h00);

    // R8 event coincides with clearing read
    cur_req = "R8";
    mode[9:8] = 2'b01;
    pin[4] = 1'b1;
    tick(3);
    chk("R8 setup bit4", status_o, 8'h10);
    pin[0] = 1'b1;
    tick(2);
    rd = 1'b1;
    tick(1);
    rd = 1'b0;
    chk("R8 coincident event kept, old cleared", status_o, 8'h01);
    chk("R8 irq stays", {7'd0, irq_o}, 8'h01);
    rd = 1'b1; tick(1); rd = 1'b0;

    // R10 mode changes
    cur_req = "R10";
    mode[11:10] = 2'b01;
    pin[5] = 1'b1;
    pin[6] = 1'b1;
    tick(3);
    chk("R10 setup bit5", status_o, 8'h20);
    mode[11:10] = 2'b00;
    mode[13:12] = 2'b11;
    tick(4);
    chk("R10 no clear, no spurious", status_o, 8'h20);
    rd = 1'b1; tick(1); rd = 1'b0;

    // R12 level at reset release
    cur_req = "R12";
    rst_n = 1'b0;
    mode = '1;
    pin = 8'hA5;
    tick(2);
    rst_n = 1'b1;
    tick(6);
    chk("R12 release level not reported", status_o, 8'h00);
    pin = 8'h5A;
    tick(3);
    chk("R4 all pins toggle together", status_o, 8'hFF);
    rd = 1'b1; tick(1); rd = 1'b0;

    // mixed traffic against model
    cur_req = "R8 mixed";
    for (int c = 0; c < 600; c++) begin
      pin = pin ^ NP'($urandom_range(0, 255) & $urandom_range(0, 255));
      if (c % 37 == 0) mode = 16'($urandom());
      rd = ($urandom_range(0, 5) == 0);
      tick(1);
    end
    rd = 1'b0;
    tick(2);
    finish_run();
  end

endmodule